// File: doc/BRIEF.md
# DMA Channel Event Status and Interrupt Collector

This block gathers two kinds of per-channel event pulses from up to eight DMA channels into one 32-bit status word. A transfer-complete pulse from channel n sets a completion flag. A pulse reporting that a channel was started while unmasked sets an error flag. Software reads the word over a simple register bus and clears flags by writing ones to them. A master that has no interrupt handler can poll a completion flag until it rises.

A single level interrupt request is raised while any flag is set and that flag's own per-channel enable is on. The enables gate only the interrupt line: flags are recorded whether or not their enable is on, so polling always works. Moving data and arbitrating between channels are handled elsewhere.

Top module: `dma_irq_status`

## Requirements
- R1: A one-cycle pulse on `done_evt[n]` sets status bit n (completion field, bits 7:0). The bit reads as 1 from the clock edge that samples the pulse.
- R2: A one-cycle pulse on `unmask_evt[n]` sets status bit 16+n (error field, bits 23:16).
- R3: A write to the status address clears each status bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R4: If an event for a bit and a write of 1 to that bit fall in the same cycle, the bit is set after that edge.
- R5: Status bits are set whether or not the matching enable (`done_ie[n]` or `unmask_ie[n]`) is on.
- R6: `irq` is registered. After each edge it equals the OR over all channels of (completion bit n AND `done_ie[n]`) and (error bit 16+n AND `unmask_ie[n]`), using the status after that edge and the enables sampled at that edge.
- R7: Status bits 15:8 and 31:24 always read 0. Writing ones to them has no effect.
- R8: After synchronous reset every status bit is 0 and `irq` is low.
- R9: A read at any address other than `STATUS_ADDR` returns 0, and a write there changes no status bit.
- R10: `bus_rdata` is registered. It shows, one cycle after `bus_rd`, the status as it stood before that edge's updates. It is 0 in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_evt | input | NUM_CH | Transfer-complete pulses, one per channel |
| unmask_evt | input | NUM_CH | Unmasked-start error pulses, one per channel |
| done_ie | input | NUM_CH | Per-channel enable of the completion interrupt |
| unmask_ie | input | NUM_CH | Per-channel enable of the error interrupt |
| bus_wr | input | 1 | Write strobe (write-1-to-clear) |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data; ones select bits to clear |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench uses the default build: eight channels, a 4-bit word address and the status register at address 0. Both 8-bit flag fields are therefore fully populated, so walking pulses touch every flag position, including channel 7 at the top of each field. The reserved bytes sit between and above the two fields where writes of all ones can probe them, and spare addresses exist to test reads and writes that miss the register. A shadow model of the flags and enables predicts every read word and the interrupt level cycle by cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned FIELD_W   = 8;
  localparam int unsigned DONE_LSB  = 0;
  localparam int unsigned ERR_LSB   = 16;
  localparam int unsigned STATUS_W  = 32;

  function automatic logic [STATUS_W-1:0] pack_status(
    input logic [FIELD_W-1:0] done_f,
    input logic [FIELD_W-1:0] err_f
  );
    logic [STATUS_W-1:0] img;
    img = '0;
    img[DONE_LSB +: FIELD_W] = done_f;
    img[ERR_LSB  +: FIELD_W] = err_f;
    return img;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] flag_nxt
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // set wins over a coincident clear
    assign flag_nxt[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_nxt[i];
    end
  end
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flag_nxt,
  input  logic [N-1:0] enable,
  output logic         irq_q
);
  logic hit;
  assign hit = |(flag_nxt & enable);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= hit;
  end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] done_evt,
  input  logic [NUM_CH-1:0] unmask_evt,
  input  logic [NUM_CH-1:0] done_ie,
  input  logic [NUM_CH-1:0] unmask_ie,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import dma_irq_pkg::*;

  localparam int unsigned PAD = FIELD_W - NUM_CH;

  logic              sel;
  logic [NUM_CH-1:0] clr_done, clr_err;
  logic [NUM_CH-1:0] done_q, err_q, done_nxt, err_nxt;
  logic [FIELD_W-1:0] done_w, err_w;
  logic [STATUS_W-1:0] image;

  assign sel      = (bus_addr == STATUS_ADDR);
  assign clr_done = (bus_wr && sel) ? bus_wdata[DONE_LSB +: NUM_CH] : '0;
  assign clr_err  = (bus_wr && sel) ? bus_wdata[ERR_LSB  +: NUM_CH] : '0;

  irq_flag_bank #(.N(NUM_CH)) u_done_bank (
    .clk(clk), .rst(rst), .set_i(done_evt), .clr_i(clr_done),
    .flag_q(done_q), .flag_nxt(done_nxt)
  );

  irq_flag_bank #(.N(NUM_CH)) u_err_bank (
    .clk(clk), .rst(rst), .set_i(unmask_evt), .clr_i(clr_err),
    .flag_q(err_q), .flag_nxt(err_nxt)
  );

  irq_line_gen #(.N(2*NUM_CH)) u_irq (
    .clk(clk), .rst(rst),
    .flag_nxt({err_nxt, done_nxt}),
    .enable({unmask_ie, done_ie}),
    .irq_q(irq)
  );

  generate
    if (PAD > 0) begin : g_pad
      assign done_w = {{PAD{1'b0}}, done_q};
      assign err_w  = {{PAD{1'b0}}, err_q};
    end else begin : g_full
      assign done_w = done_q;
      assign err_w  = err_q;
    end
  endgenerate

  assign image = pack_status(done_w, err_w);

  always_ff @(posedge clk) begin
    if (rst)                 bus_rdata <= '0;
    else if (bus_rd && sel)  bus_rdata <= DATA_W'(image);
    else                     bus_rdata <= '0;
  end
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] done_evt,
  input logic [NUM_CH-1:0] unmask_evt,
  input logic [NUM_CH-1:0] done_ie,
  input logic [NUM_CH-1:0] unmask_ie,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [NUM_CH-1:0] done_flags,
  input logic [NUM_CH-1:0] err_flags
);
  import dma_irq_pkg::*;

  logic hit_wr;
  assign hit_wr = bus_wr && (bus_addr == STATUS_ADDR);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    p_done_set_r1: assert property (@(posedge clk) disable iff (rst)
      done_evt[c] |=> done_flags[c]);
    p_err_set_r2: assert property (@(posedge clk) disable iff (rst)
      unmask_evt[c] |=> err_flags[c]);
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (hit_wr && bus_wdata[DONE_LSB + c] && !done_evt[c]) |=> !done_flags[c]);
    p_keep_r3: assert property (@(posedge clk) disable iff (rst)
      (done_flags[c] && !(hit_wr && bus_wdata[DONE_LSB + c])) |=> done_flags[c]);
  end

  p_irq_level_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (|((done_flags & $past(done_ie)) | (err_flags & $past(unmask_ie))))));

  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[15:8] == 8'h00) && (bus_rdata[31:24] == 8'h00));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!irq && done_flags == '0 && err_flags == '0));

  p_miss_read_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr != STATUS_ADDR) |=> (bus_rdata == '0));

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind dma_irq_status dma_irq_status_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .done_evt(done_evt), .unmask_evt(unmask_evt),
  .done_ie(done_ie), .unmask_ie(unmask_ie), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .done_flags(done_q), .err_flags(err_q)
);

// File: tb/dma_irq_status_tb.sv
module dma_irq_status_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  done_evt = '0, unmask_evt = '0, done_ie = '0, unmask_ie = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  logic [7:0]  m_done = '0, m_err = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_status u_dut (
    .clk(clk), .rst(rst), .done_evt(done_evt), .unmask_evt(unmask_evt),
    .done_ie(done_ie), .unmask_ie(unmask_ie), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] img();
    return {8'h00, m_err, 8'h00, m_done};
  endfunction

  // monitor: compares read data the cycle after a read strobe
  always_ff @(posedge clk) rd_d <= bus_rd;

  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s rdata actual=%08h expected=%08h", t, bus_rdata, e);
      end
    end else if (!rst) begin
      checks++;
      if (bus_rdata !== 32'h0) begin
        fails++;
        $display("FAIL R10 idle rdata actual=%08h expected=00000000", bus_rdata);
      end
    end
  end

  // driver: one cycle of stimulus, model update, irq check
  task automatic step(input logic [7:0] d, input logic [7:0] e,
                      input logic wr, input logic rd, input logic [3:0] a,
                      input logic [31:0] wd, input string tag);
    logic exp_irq;
    done_evt = d; unmask_evt = e; bus_wr = wr; bus_rd = rd;
    bus_addr = a; bus_wdata = wd;
    if (rd) begin
      exp_q.push_back((a == 4'h0) ? img() : 32'h0);
      tag_q.push_back(tag);
    end
    if (wr && a == 4'h0) begin
      m_done = m_done & ~wd[7:0];
      m_err  = m_err  & ~wd[23:16];
    end
    m_done = m_done | d;
    m_err  = m_err  | e;
    exp_irq = |((m_done & done_ie) | (m_err & unmask_ie));
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (irq !== exp_irq) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp_irq);
    end
  endtask

  task automatic rd_stat(input string tag);
    step('0, '0, 1'b0, 1'b1, 4'h0, '0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    checks++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R8 irq actual=%0b expected=0", irq); end
    rd_stat("R8");
    step('0, '0, 1'b0, 1'b0, 4'h0, '0, "R8");

    // R1 and R5: walk completion pulses with enables off
    for (int c = 0; c < 8; c++) begin
      step(8'(1 << c), '0, 1'b0, 1'b0, 4'h0, '0, "R5");
      rd_stat("R1");
    end
    // R3: write 0 keeps, write 1 clears a subset
    step('0, '0, 1'b1, 1'b0, 4'h0, 32'h0000_0000, "R3");
    rd_stat("R3");
    step('0, '0, 1'b1, 1'b0, 4'h0, 32'h0000_00A5, "R3");
    rd_stat("R3");
    // R2: error pulses on several channels
    step('0, 8'h81, 1'b0, 1'b0, 4'h0, '0, "R2");
    step('0, 8'h18, 1'b0, 1'b0, 4'h0, '0, "R2");
    rd_stat("R2");
    // R7: ones into reserved bytes change nothing
    step('0, '0, 1'b1, 1'b0, 4'h0, 32'hFF00_FF00, "R7");
    rd_stat("R7");
    // R9: miss address writes/reads
    step('0, '0, 1'b1, 1'b0, 4'h3, 32'hFFFF_FFFF, "R9");
    step('0, '0, 1'b0, 1'b1, 4'h5, '0, "R9");
    rd_stat("R9");
    // R6: enables gate the irq line
    done_ie = 8'h02;
    step('0, '0, 1'b0, 1'b0, 4'h0, '0, "R6");
    step('0, '0, 1'b1, 1'b0, 4'h0, 32'h0000_0002, "R6");
    unmask_ie = 8'h10;
    step('0, '0, 1'b0, 1'b0, 4'h0, '0, "R6");
    step('0, '0, 1'b1, 1'b0, 4'h0, 32'h0010_0000, "R6");
    step('0, 8'h10, 1'b0, 1'b0, 4'h0, '0, "R6");
    // R4: event coincident with clear keeps the bit
    step(8'h40, 8'h02, 1'b1, 1'b0, 4'h0, 32'h0002_0040, "R4");
    rd_stat("R4");
    // R10: read sees pre-update value while an event lands
    step(8'h01, '0, 1'b1, 1'b1, 4'h0, 32'hFFFF_FFFF, "R10");
    rd_stat("R10");
    // clear everything, irq drops
    step('0, '0, 1'b1, 1'b0, 4'h0, 32'hFFFF_FFFF, "R3");
    rd_stat("R3");
    step('0, '0, 1'b0, 1'b0, 4'h0, '0, "R6");

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule